// File: doc/BRIEF.md
# Weekly Minute-Resolution Alarm Comparator

This unit sits next to a running calendar counter and watches its BCD seconds, minutes and hours along with a binary weekday code. Software programs an alarm minute and hour in BCD and a seven-bit weekday selection mask through a small register port. When the seconds field rolls over to 00 and the minute, the hour and the mask bit of the current weekday all agree, the unit raises a sticky interrupt flag. The flag drives the interrupt output and stays set until software clears it.

Resolution is one minute, and the day is chosen by weekday rather than by date. An alarm can therefore never lie more than seven days ahead. Setting several mask bits gives an alarm that repeats on each of the selected days. The interrupt is gated by an enable bit. No alarm is taken while the counter is held.

Top module: `rtc_weekly_alarm`

## Requirements
- R1: After a synchronous reset, the minute, hour, mask and enable fields read as zero, the flag is clear and `alarm_irq` is low.
- R2: The register map is as follows. Address 0 holds the alarm minute in bits 6:0. Address 1 holds the alarm hour in bits 5:0. Address 2 holds the weekday mask, where bit n selects weekday code n for n from 0 to 6. Address 3 is control: bit 0 is the enable and bit 1 reads the flag. Unused bits read 0. `reg_rdata` shows the register named by `reg_raddr` one cycle after that address is sampled, and it shows the value held before any write in that same cycle.
- R3: The flag is set at the clock edge where `cur_sec` is 00 and was non-zero at the previous edge, provided that `cur_min` equals the alarm minute, `cur_hour` equals the alarm hour, the mask bit for `cur_wday` is 1 and the enable is 1. `alarm_irq` is high from that edge onward.
- R4: A match is taken only once per rollover. While seconds stay at 00, a flag that has been cleared stays clear.
- R5: A rollover whose minute, hour or weekday mask bit differs from the alarm does not set the flag.
- R6: With the enable at 0, a rollover that otherwise matches does not set the flag.
- R7: While `count_hold` is high, a rollover does not set the flag.
- R8: The flag is sticky. Only a write to address 3 with bit 1 set clears it. A write to address 3 with bit 1 clear leaves it unchanged.
- R9: When a clearing write and a match fall in the same cycle, the flag ends up set.
- R10: When several mask bits are set, the alarm fires on each selected weekday and on no unselected weekday.
- R11: Weekday code 7 matches no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD (24 h) |
| cur_wday | input | 3 | Current weekday code, 0 to 6 |
| count_hold | input | 1 | Calendar counter is held |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 8 | Registered read data |
| alarm_irq | output | 1 | Sticky alarm interrupt |

## Verification
The bench targets the rollover edge. A design that compares on level instead of on the 59-to-00 transition would set the flag again after a clear while seconds stay at 00. The bench also exercises a clear and a match in the same cycle, where a clear-priority design would lose the alarm. It covers a held counter, which must suppress the alarm, and a multi-day mask, where a design that decoded the weekday wrongly would fire on the wrong days or on code 7. Field truncation on write and the one-cycle read latency are checked as well, so that an off-by-one width or an unregistered read shows up on `reg_rdata`.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int REG_ADDR_W    = 2;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_MIN  = 2'd0,
    A_HOUR = 2'd1,
    A_WDAY = 2'd2,
    A_CTRL = 2'd3
  } alarm_addr_e;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int WDAYS  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  input  logic                  flag_i,
  output logic [MIN_W-1:0]      alm_min,
  output logic [HOUR_W-1:0]     alm_hour,
  output logic [WDAYS-1:0]      alm_mask,
  output logic                  alm_en,
  output logic                  clr_flag,
  output logic [DATA_W-1:0]     rd_data
);
  logic [MIN_W-1:0]  min_q;
  logic [HOUR_W-1:0] hour_q;
  logic [WDAYS-1:0]  mask_q;
  logic              en_q;
  logic [DATA_W-1:0] rd_q, rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wr_data;

  always_comb begin
    rd_mux = '0;
    case (alarm_addr_e'(rd_addr))
      A_MIN:  rd_mux[MIN_W-1:0]  = min_q;
      A_HOUR: rd_mux[HOUR_W-1:0] = hour_q;
      A_WDAY: rd_mux[WDAYS-1:0]  = mask_q;
      A_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = en_q;
        rd_mux[CTRL_FLAG_BIT] = flag_i;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_q  <= '0;
      hour_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (wr_en) begin
        case (alarm_addr_e'(wr_addr))
          A_MIN:  min_q  <= wr_data[MIN_W-1:0];
          A_HOUR: hour_q <= wr_data[HOUR_W-1:0];
          A_WDAY: mask_q <= wr_data[WDAYS-1:0];
          A_CTRL: en_q   <= wr_data[CTRL_EN_BIT];
          default: ;
        endcase
      end
      rd_q <= rd_mux;
    end
  end

  assign clr_flag = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_FLAG_BIT];
  assign alm_min  = min_q;
  assign alm_hour = hour_q;
  assign alm_mask = mask_q;
  assign alm_en   = en_q;
  assign rd_data  = rd_q;

  // R2: enable follows a control write one cycle later
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTRL) |=> (alm_en == $past(wr_data[CTRL_EN_BIT])));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int TIME_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int WDAYS  = 7,
  parameter int WDAY_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] cur_sec,
  input  logic [TIME_W-1:0] cur_min,
  input  logic [TIME_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              hold,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [WDAYS-1:0]  alm_mask,
  output logic              hit
);
  logic              sec_zero_q;
  logic              rolled;
  logic [WDAYS-1:0]  day_oh;
  logic              day_sel, min_eq, hour_eq;

  for (genvar i = 0; i < WDAYS; i++) begin : g_day
    assign day_oh[i] = (cur_wday == WDAY_W'(i));
  end

  assign day_sel = |(day_oh & alm_mask);
  assign min_eq  = (cur_min  == TIME_W'(alm_min));
  assign hour_eq = (cur_hour == TIME_W'(alm_hour));
  assign rolled  = (cur_sec == '0) && !sec_zero_q;
  assign hit     = rolled && !hold && min_eq && hour_eq && day_sel;

  always_ff @(posedge clk) begin
    if (rst) sec_zero_q <= 1'b1;
    else     sec_zero_q <= (cur_sec == '0);
  end

  // R4: a match never lasts two consecutive cycles
  assert_single_hit_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/rtc_weekly_alarm.sv
module rtc_weekly_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int WDAYS  = 7,
  parameter int WDAY_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] cur_sec,
  input  logic [TIME_W-1:0] cur_min,
  input  logic [TIME_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              count_hold,
  input  logic              reg_we,
  input  logic [1:0]        reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              alarm_irq
);
  logic [MIN_W-1:0]  alm_min;
  logic [HOUR_W-1:0] alm_hour;
  logic [WDAYS-1:0]  alm_mask;
  logic              alm_en, clr_flag, hit, set_flag, flag_q;

  rtc_alarm_regs #(.DATA_W(DATA_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .WDAYS(WDAYS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .flag_i(flag_q), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_mask(alm_mask), .alm_en(alm_en), .clr_flag(clr_flag), .rd_data(reg_rdata)
  );

  rtc_alarm_match #(.TIME_W(TIME_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .WDAYS(WDAYS),
                    .WDAY_W(WDAY_W)) u_match (
    .clk(clk), .rst(rst), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .hold(count_hold), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_mask(alm_mask), .hit(hit)
  );

  assign set_flag = hit && alm_en;

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (set_flag) flag_q <= 1'b1;
    else if (clr_flag) flag_q <= 1'b0;
  end

  assign alarm_irq = flag_q;

  // R3 and R9: an enabled match sets the flag, even against a clear
  assert_match_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && alm_en) |=> alarm_irq);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (hit && alm_en && clr_flag) |=> alarm_irq);
  // R8: sticky without a clear
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (alarm_irq && !clr_flag) |=> alarm_irq);
  // R6: disabled alarm never raises the flag
  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (!alarm_irq && !alm_en) |=> !alarm_irq);
  // R7: held counter never raises the flag
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!alarm_irq && count_hold) |=> !alarm_irq);
endmodule

// File: tb/rtc_weekly_alarm_bench.sv
module rtc_weekly_alarm_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic       count_hold = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_waddr = '0, reg_raddr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_irq;

  int checks = 0;
  int errors = 0;

  // scoreboard queues
  bit         q_irq[$];
  logic [7:0] q_rd[$];
  string      q_tag[$];

  // requirement-level model
  logic [6:0] m_min = '0;
  logic [5:0] m_hour = '0;
  logic [6:0] m_mask = '0;
  logic       m_en = 1'b0, m_flag = 1'b0;
  logic [7:0] m_prev = '0;

  always #4 clk = ~clk;

  rtc_weekly_alarm u_rtc_weekly_alarm (
    .clk(clk), .rst(rst), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .count_hold(count_hold), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  function automatic logic [7:0] mread(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_min};
      2'd1: return {2'b0, m_hour};
      2'd2: return {1'b0, m_mask};
      default: return {6'b0, m_flag, m_en};
    endcase
  endfunction

  task automatic cyc(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                     input logic [2:0] wd, input logic hd, input logic we,
                     input logic [1:0] wa, input logic [7:0] wdat,
                     input logic [1:0] ra, input string tag);
    logic ev, hitm, clr;
    logic [7:0] erd;
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = wd; count_hold = hd;
    reg_we = we; reg_waddr = wa; reg_wdata = wdat; reg_raddr = ra;
    erd  = mread(ra);
    ev   = (m_prev != 8'h00) && (s == 8'h00) && !hd;
    hitm = ev && (m == {1'b0, m_min}) && (h == {2'b0, m_hour}) && (wd < 3'd7) && m_mask[wd];
    clr  = we && (wa == 2'd3) && wdat[1];
    if (hitm && m_en) m_flag = 1'b1;
    else if (clr)     m_flag = 1'b0;
    if (we) begin
      case (wa)
        2'd0: m_min  = wdat[6:0];
        2'd1: m_hour = wdat[5:0];
        2'd2: m_mask = wdat[6:0];
        default: m_en = wdat[0];
      endcase
    end
    m_prev = s;
    q_irq.push_back(m_flag);
    q_rd.push_back(erd);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(8'h30, 8'h00, 8'h10, 3'd1, 1'b0, 1'b1, a, d, 2'd3, tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(8'h30, 8'h00, 8'h10, 3'd1, 1'b0, 1'b0, 2'd0, 8'h00, a, tag);
  endtask

  // one rollover: 59 then 00, reading control so the flag is visible
  task automatic tick(input logic [7:0] m, input logic [7:0] h, input logic [2:0] wd,
                      input logic hd, input string tag);
    cyc(8'h59, m, h, wd, 1'b0, 1'b0, 2'd0, 8'h00, 2'd3, tag);
    cyc(8'h00, m, h, wd, hd,   1'b0, 2'd0, 8'h00, 2'd3, tag);
    cyc(8'h00, m, h, wd, 1'b0, 1'b0, 2'd0, 8'h00, 2'd3, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_irq.size() > 0) begin
        bit e_irq;
        logic [7:0] e_rd;
        string t;
        e_irq = q_irq.pop_front();
        e_rd  = q_rd.pop_front();
        t     = q_tag.pop_front();
        checks += 2;
        if (alarm_irq !== e_irq) begin
          errors++;
          $display("FAIL %s alarm_irq got %0b exp %0b", t, alarm_irq, e_irq);
        end
        if (reg_rdata !== e_rd) begin
          errors++;
          $display("FAIL %s reg_rdata got %02h exp %02h", t, reg_rdata, e_rd);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R1");
    // R2 field truncation and readback
    wr(2'd0, 8'hFF, "R2"); rd(2'd0, "R2");
    wr(2'd1, 8'hFF, "R2"); rd(2'd1, "R2");
    wr(2'd2, 8'hFF, "R2"); rd(2'd2, "R2");
    wr(2'd0, 8'h45, "R2"); wr(2'd1, 8'h13, "R2"); wr(2'd2, 8'h04, "R2");
    wr(2'd3, 8'h01, "R2");
    rd(2'd0, "R2"); rd(2'd1, "R2"); rd(2'd2, "R2"); rd(2'd3, "R2");
    // R3 matching rollover
    tick(8'h45, 8'h13, 3'd2, 1'b0, "R3");
    // R8 sticky: write without clear bit keeps the flag
    cyc(8'h00, 8'h45, 8'h13, 3'd2, 1'b0, 1'b1, 2'd3, 8'h01, 2'd3, "R8");
    cyc(8'h00, 8'h45, 8'h13, 3'd2, 1'b0, 1'b0, 2'd0, 8'h00, 2'd3, "R8");
    // R4 clear while seconds stay at 00: no re-trigger
    cyc(8'h00, 8'h45, 8'h13, 3'd2, 1'b0, 1'b1, 2'd3, 8'h03, 2'd3, "R4");
    cyc(8'h00, 8'h45, 8'h13, 3'd2, 1'b0, 1'b0, 2'd0, 8'h00, 2'd3, "R4");
    cyc(8'h00, 8'h45, 8'h13, 3'd2, 1'b0, 1'b0, 2'd0, 8'h00, 2'd3, "R4");
    // R5 mismatches
    tick(8'h46, 8'h13, 3'd2, 1'b0, "R5");
    tick(8'h45, 8'h14, 3'd2, 1'b0, "R5");
    tick(8'h45, 8'h13, 3'd3, 1'b0, "R5");
    // R6 disabled
    wr(2'd3, 8'h00, "R6");
    tick(8'h45, 8'h13, 3'd2, 1'b0, "R6");
    wr(2'd3, 8'h01, "R6");
    // R7 held counter
    tick(8'h45, 8'h13, 3'd2, 1'b1, "R7");
    // R9 clear and match in the same cycle
    cyc(8'h59, 8'h45, 8'h13, 3'd2, 1'b0, 1'b0, 2'd0, 8'h00, 2'd3, "R9");
    cyc(8'h00, 8'h45, 8'h13, 3'd2, 1'b0, 1'b1, 2'd3, 8'h03, 2'd3, "R9");
    cyc(8'h00, 8'h45, 8'h13, 3'd2, 1'b0, 1'b0, 2'd0, 8'h00, 2'd3, "R9");
    wr(2'd3, 8'h03, "R9");
    // R10 multiple days: codes 0, 4, 6
    wr(2'd2, 8'h51, "R10");
    for (int d = 0; d < 7; d++) begin
      tick(8'h45, 8'h13, 3'(d), 1'b0, "R10");
      wr(2'd3, 8'h03, "R10");
    end
    // R11 weekday code 7 with all mask bits
    wr(2'd2, 8'h7F, "R11");
    tick(8'h45, 8'h13, 3'd7, 1'b0, "R11");
    rd(2'd3, "R11");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule